// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits behind the write side of a NOR-style flash with a 32-bit data bus and turns bus writes into flash operations. In the idle state every write is a command: only the low byte of the written word is decoded and the address plays no part. Some commands only switch what the read path returns (array data, status, identification or query data). Others open a two-step sequence whose second write carries the operand: a word to program, a block to erase, a block to lock or unlock, or the word count and data of a buffered program.

The block keeps the operation state, the read-mode selector, an 8-bit status value and a per-block lock bitmap. Array writes, block erases (filling a 64 KiB block with 0xFF) and buffer commits are handed to neighbouring engines through request/done handshakes. While one of them is outstanding the status ready bit is low and further bus writes are dropped. Errors never reject a sequence outright. They set sticky status bits that only the clear-status command removes.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the read mode is array (code 0), status_o is 0x80, no block is locked and no request is active. Read-mode codes are: array 0, status 1, identification 2, query 3.
- R2: In the idle state only wr_data[7:0] is decoded; wr_data[31:8] and wr_addr have no effect on a command.
- R3: In the idle state 0x90 selects identification mode, 0x70 status mode, 0x98 query mode, and 0xFF or any unlisted code selects array mode; 0xD0 changes nothing.
- R4: In the idle state 0x50 returns status_o to 0x80.
- R5: 0x60 opens a lock sequence without touching the read mode. The next write locks (0x01) or unlocks (0xD0) the block wr_addr[ADDR_W-1:16] and selects status mode; any other code ORs 0x30 into status. The sequence then ends.
- R6: 0x40 or 0x10 selects status mode. The next write raises prog_req_o with that write's address, data and length, unless its block is locked, in which case 0x12 is ORed into status and nothing is requested.
- R7: 0x20 selects status mode. A following 0xD0 raises erase_req_o for the addressed block if it is unlocked, or ORs 0x12 if locked; any other code ORs 0x30. The sequence always ends in status mode.
- R8: 0xE8 pulses buf_init_o and selects status mode. The next write pulses buf_cnt_we_o with its low byte on buf_cnt_o. Later writes pulse buf_wr_o and continue while buf_accept_i is high. A refused 0xD0 raises buf_commit_o, or ORs 0x12 if the block of buf_base_i is locked. A refused write of any other code ORs 0x10 and leaves the read mode alone.
- R9: While a request is outstanding, status bit 7 is 0, the request and its fields hold until the matching done input, and bus writes are ignored. Bit 7 returns to 1 when done is seen.
- R10: Error bits in status_o[6:0] are sticky; only command 0x50 clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Written value |
| wr_len | input | LEN_W | Write length in bytes |
| rd_mode_o | output | 2 | Read-mode selector for the read mux |
| status_o | output | 8 | Status value |
| lock_map_o | output | NUM_BLOCKS | Lock bit per 64 KiB block |
| prog_req_o | output | 1 | Word program request |
| prog_addr_o | output | ADDR_W | Program address |
| prog_data_o | output | 32 | Program data |
| prog_len_o | output | LEN_W | Program length |
| prog_done_i | input | 1 | Program completed |
| erase_req_o | output | 1 | Block erase request |
| erase_blk_o | output | BLK_W | Block index to erase |
| erase_done_i | input | 1 | Erase completed |
| buf_init_o | output | 1 | Buffer reset pulse |
| buf_cnt_we_o | output | 1 | Word-count write pulse |
| buf_cnt_o | output | 8 | Word-count value |
| buf_wr_o | output | 1 | Data write offered to the buffer |
| buf_accept_i | input | 1 | Buffer takes the offered write (same cycle) |
| buf_base_i | input | ADDR_W | Base address held by the buffer |
| buf_commit_o | output | 1 | Buffer commit request |
| buf_commit_done_i | input | 1 | Commit completed |

## Verification
The checker assumes that each done input rises only while its own request is high, and that buf_accept_i is a same-cycle answer to buf_wr_o. The stimulus respects both: bench responders raise done a set number of cycles after seeing a request and drop it once the request falls. The accept input is derived from the offered data. The random phase draws command bytes from the decoded set plus arbitrary bytes, with random upper bits and addresses. After each write it waits for the ready bit, so all overlapping traffic comes from the directed busy case.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_LOCK_ARM, ST_WORD_ARM, ST_BUF_COUNT, ST_BUF_FILL, ST_ERASE_ARM
   } seq_state_t;

   typedef enum logic [1:0] {
      RM_ARRAY = 2'd0, RM_STATUS = 2'd1, RM_IDENT = 2'd2, RM_QUERY = 2'd3
   } rd_mode_t;

   typedef enum logic [1:0] {
      OP_NONE, OP_PROG, OP_ERASE, OP_COMMIT
   } pend_op_t;

   localparam logic [7:0] C_IDENT    = 8'h90;
   localparam logic [7:0] C_STATUS   = 8'h70;
   localparam logic [7:0] C_QUERY    = 8'h98;
   localparam logic [7:0] C_CLEAR    = 8'h50;
   localparam logic [7:0] C_WORD_A   = 8'h40;
   localparam logic [7:0] C_WORD_B   = 8'h10;
   localparam logic [7:0] C_ERASE    = 8'h20;
   localparam logic [7:0] C_BUFFER   = 8'hE8;
   localparam logic [7:0] C_LOCKSEQ  = 8'h60;
   localparam logic [7:0] C_LOCK_SET = 8'h01;
   localparam logic [7:0] C_CONFIRM  = 8'hD0;

   localparam logic [6:0] E_LOCKED = 7'h12;
   localparam logic [6:0] E_SEQ    = 7'h30;
   localparam logic [6:0] E_BUF    = 7'h10;

endpackage

// File: rtl/flash_cmd_lockmap.sv
module flash_cmd_lockmap #(
   parameter int IDX_W = 4,
   localparam int N    = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_en,
   input  logic             upd_val,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic [IDX_W-1:0] qa_idx,
   input  logic [IDX_W-1:0] qb_idx,
   output logic [N-1:0]     map_o,
   output logic             qa_locked,
   output logic             qb_locked
);

   for (genvar b = 0; b < N; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            map_o[b] <= 1'b0;
         else if (upd_en && (upd_idx == IDX_W'(b)))
            map_o[b] <= upd_val;
      end
   end

   assign qa_locked = map_o[qa_idx];
   assign qb_locked = map_o[qb_idx];

endmodule

// File: rtl/flash_cmd_status.sv
module flash_cmd_status (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_i,
   input  logic [6:0] set_i,
   input  logic       busy_i,
   output logic [7:0] status_o
);

   logic [6:0] err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     err_q <= '0;
      else if (clr_i) err_q <= '0;
      else            err_q <= err_q | set_i;
   end

   assign status_o = {~busy_i, err_q};

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int BLK_LOG2   = 16,
   parameter int LEN_W      = 3,
   localparam int BLK_W      = ADDR_W - BLK_LOG2,
   localparam int NUM_BLOCKS = 1 << BLK_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [31:0]           wr_data,
   input  logic [LEN_W-1:0]      wr_len,
   output logic [1:0]            rd_mode_o,
   output logic [7:0]            status_o,
   output logic [NUM_BLOCKS-1:0] lock_map_o,
   output logic                  prog_req_o,
   output logic [ADDR_W-1:0]     prog_addr_o,
   output logic [31:0]           prog_data_o,
   output logic [LEN_W-1:0]      prog_len_o,
   input  logic                  prog_done_i,
   output logic                  erase_req_o,
   output logic [BLK_W-1:0]      erase_blk_o,
   input  logic                  erase_done_i,
   output logic                  buf_init_o,
   output logic                  buf_cnt_we_o,
   output logic [7:0]            buf_cnt_o,
   output logic                  buf_wr_o,
   input  logic                  buf_accept_i,
   input  logic [ADDR_W-1:0]     buf_base_i,
   output logic                  buf_commit_o,
   input  logic                  buf_commit_done_i
);

   if (BLK_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed BLK_LOG2");
   end
   if (BLK_W > 12) begin : g_bad_blocks
      $error("lock bitmap too large for a register array");
   end
   if (LEN_W < 1) begin : g_bad_len
      $error("LEN_W must be at least 1");
   end

   seq_state_t st_q, st_n;
   rd_mode_t   mode_q, mode_n;
   pend_op_t   op_q, op_n;

   logic [7:0]       cmd;
   logic [BLK_W-1:0] wr_blk, base_blk;
   logic             wr_locked, base_locked;
   logic             busy, done_hit;
   logic             lk_en, lk_val, st_clr, ld_prog, ld_erase;
   logic [6:0]       err_set;

   assign cmd      = wr_data[7:0];
   assign wr_blk   = wr_addr[ADDR_W-1:BLK_LOG2];
   assign base_blk = buf_base_i[ADDR_W-1:BLK_LOG2];
   assign busy     = (op_q != OP_NONE);
   assign done_hit = (op_q == OP_PROG   && prog_done_i)  ||
                     (op_q == OP_ERASE  && erase_done_i) ||
                     (op_q == OP_COMMIT && buf_commit_done_i);

   flash_cmd_lockmap #(.IDX_W(BLK_W)) u_locks (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_en    (lk_en),
      .upd_val   (lk_val),
      .upd_idx   (wr_blk),
      .qa_idx    (wr_blk),
      .qb_idx    (base_blk),
      .map_o     (lock_map_o),
      .qa_locked (wr_locked),
      .qb_locked (base_locked)
   );

   flash_cmd_status u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (st_clr),
      .set_i    (err_set),
      .busy_i   (busy),
      .status_o (status_o)
   );

   always_comb begin
      st_n         = st_q;
      mode_n       = mode_q;
      op_n         = op_q;
      lk_en        = 1'b0;
      lk_val       = 1'b0;
      st_clr       = 1'b0;
      err_set      = '0;
      ld_prog      = 1'b0;
      ld_erase     = 1'b0;
      buf_init_o   = 1'b0;
      buf_cnt_we_o = 1'b0;
      buf_wr_o     = 1'b0;
      if (busy) begin
         if (done_hit) op_n = OP_NONE;
      end else if (wr_en) begin
         unique case (st_q)
            ST_IDLE: begin
               unique case (cmd)
                  C_IDENT:  mode_n = RM_IDENT;
                  C_STATUS: mode_n = RM_STATUS;
                  C_QUERY:  mode_n = RM_QUERY;
                  C_CLEAR:  st_clr = 1'b1;
                  C_WORD_A, C_WORD_B: begin
                     st_n = ST_WORD_ARM;  mode_n = RM_STATUS;
                  end
                  C_ERASE: begin
                     st_n = ST_ERASE_ARM; mode_n = RM_STATUS;
                  end
                  C_BUFFER: begin
                     buf_init_o = 1'b1;
                     st_n = ST_BUF_COUNT; mode_n = RM_STATUS;
                  end
                  C_LOCKSEQ: st_n = ST_LOCK_ARM;
                  C_CONFIRM: ;
                  default:   mode_n = RM_ARRAY;
               endcase
            end
            ST_LOCK_ARM: begin
               if (cmd == C_LOCK_SET || cmd == C_CONFIRM) begin
                  lk_en  = 1'b1;
                  lk_val = (cmd == C_LOCK_SET);
                  mode_n = RM_STATUS;
               end else begin
                  err_set = E_SEQ;
               end
               st_n = ST_IDLE;
            end
            ST_WORD_ARM: begin
               if (wr_locked) err_set = E_LOCKED;
               else begin
                  ld_prog = 1'b1;
                  op_n    = OP_PROG;
               end
               mode_n = RM_STATUS;
               st_n   = ST_IDLE;
            end
            ST_BUF_COUNT: begin
               buf_cnt_we_o = 1'b1;
               mode_n       = RM_STATUS;
               st_n         = ST_BUF_FILL;
            end
            ST_BUF_FILL: begin
               buf_wr_o = 1'b1;
               if (!buf_accept_i) begin
                  if (cmd == C_CONFIRM) begin
                     if (base_locked) err_set = E_LOCKED;
                     else             op_n    = OP_COMMIT;
                     mode_n = RM_STATUS;
                  end else begin
                     err_set = E_BUF;
                  end
                  st_n = ST_IDLE;
               end
            end
            ST_ERASE_ARM: begin
               if (cmd != C_CONFIRM) err_set = E_SEQ;
               else if (wr_locked)   err_set = E_LOCKED;
               else begin
                  ld_erase = 1'b1;
                  op_n     = OP_ERASE;
               end
               mode_n = RM_STATUS;
               st_n   = ST_IDLE;
            end
            default: st_n = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         mode_q      <= RM_ARRAY;
         op_q        <= OP_NONE;
         prog_addr_o <= '0;
         prog_data_o <= '0;
         prog_len_o  <= '0;
         erase_blk_o <= '0;
      end else begin
         st_q   <= st_n;
         mode_q <= mode_n;
         op_q   <= op_n;
         if (ld_prog) begin
            prog_addr_o <= wr_addr;
            prog_data_o <= wr_data;
            prog_len_o  <= wr_len;
         end
         if (ld_erase) erase_blk_o <= wr_blk;
      end
   end

   assign rd_mode_o    = mode_q;
   assign buf_cnt_o    = cmd;
   assign prog_req_o   = (op_q == OP_PROG);
   assign erase_req_o  = (op_q == OP_ERASE);
   assign buf_commit_o = (op_q == OP_COMMIT);

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
   parameter int ADDR_W     = 20,
   parameter int BLK_W      = 4,
   parameter int NUM_BLOCKS = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wr_en,
   input logic [31:0]           wr_data,
   input logic [1:0]            rd_mode_o,
   input logic [7:0]            status_o,
   input logic [NUM_BLOCKS-1:0] lock_map_o,
   input logic                  prog_req_o,
   input logic [ADDR_W-1:0]     prog_addr_o,
   input logic                  prog_done_i,
   input logic                  erase_req_o,
   input logic [BLK_W-1:0]      erase_blk_o,
   input logic                  buf_commit_o
);

   // R9: an outstanding request keeps the ready bit low
   a_r9_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_req_o || erase_req_o || buf_commit_o) |-> !status_o[7]);

   // R9: never more than one engine requested
   a_r9_single_op: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prog_req_o, erase_req_o, buf_commit_o}));

   // R9: program request and address hold until done
   a_r9_prog_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_req_o && !prog_done_i) |=> (prog_req_o && $stable(prog_addr_o)));

   // R7: an erase is only requested on an unlocked block
   a_r7_erase_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req_o |-> !lock_map_o[erase_blk_o]);

   // R7: erase runs with the read mode on status
   a_r7_erase_status_mode: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req_o |-> (rd_mode_o == 2'd1));

   // R10: an error bit only falls after a clear command
   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_o[4]) |-> $past(wr_en && wr_data[7:0] == 8'h50));

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
   .ADDR_W(ADDR_W), .BLK_W(BLK_W), .NUM_BLOCKS(NUM_BLOCKS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
   .rd_mode_o(rd_mode_o), .status_o(status_o), .lock_map_o(lock_map_o),
   .prog_req_o(prog_req_o), .prog_addr_o(prog_addr_o), .prog_done_i(prog_done_i),
   .erase_req_o(erase_req_o), .erase_blk_o(erase_blk_o), .buf_commit_o(buf_commit_o)
);

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [19:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  wr_len = '0;
   logic [1:0]  rd_mode_o;
   logic [7:0]  status_o;
   logic [15:0] lock_map_o;
   logic        prog_req_o, erase_req_o, buf_commit_o;
   logic [19:0] prog_addr_o;
   logic [31:0] prog_data_o;
   logic [2:0]  prog_len_o;
   logic [3:0]  erase_blk_o;
   logic        prog_done_i = 1'b0, erase_done_i = 1'b0, commit_done_i = 1'b0;
   logic        buf_init_o, buf_cnt_we_o, buf_wr_o;
   logic [7:0]  buf_cnt_o;
   logic        accept_en = 1'b1;
   logic [19:0] tb_base = 20'h7_0040;
   logic        buf_accept_i;

   assign buf_accept_i = accept_en && (wr_data[7:0] != 8'hD0);

   always #5 clk = ~clk;

   flash_cmd_seq dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_len(wr_len), .rd_mode_o(rd_mode_o),
      .status_o(status_o), .lock_map_o(lock_map_o),
      .prog_req_o(prog_req_o), .prog_addr_o(prog_addr_o),
      .prog_data_o(prog_data_o), .prog_len_o(prog_len_o), .prog_done_i(prog_done_i),
      .erase_req_o(erase_req_o), .erase_blk_o(erase_blk_o), .erase_done_i(erase_done_i),
      .buf_init_o(buf_init_o), .buf_cnt_we_o(buf_cnt_we_o), .buf_cnt_o(buf_cnt_o),
      .buf_wr_o(buf_wr_o), .buf_accept_i(buf_accept_i), .buf_base_i(tb_base),
      .buf_commit_o(buf_commit_o), .buf_commit_done_i(commit_done_i)
   );

   int tests = 0, fails = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // engine responders and request monitor
   int hold = 2, rcnt = 0;
   bit seen_prog, seen_erase, seen_com;
   logic [19:0] s_paddr; logic [31:0] s_pdata; logic [2:0] s_plen; logic [3:0] s_blk;
   always @(negedge clk) begin
      if (prog_req_o || erase_req_o || buf_commit_o) begin
         if (prog_req_o)   begin seen_prog = 1; s_paddr = prog_addr_o; s_pdata = prog_data_o; s_plen = prog_len_o; end
         if (erase_req_o)  begin seen_erase = 1; s_blk = erase_blk_o; end
         if (buf_commit_o) seen_com = 1;
         rcnt++;
         prog_done_i   = prog_req_o   && (rcnt >= hold);
         erase_done_i  = erase_req_o  && (rcnt >= hold);
         commit_done_i = buf_commit_o && (rcnt >= hold);
         if (rcnt >= hold) rcnt = 0;
      end else begin
         rcnt = 0;
         prog_done_i = 0; erase_done_i = 0; commit_done_i = 0;
      end
   end

   bit cap_init, cap_cnt_we, cap_wr;
   logic [7:0] cap_cnt;

   task automatic do_wr(input logic [19:0] a, input logic [31:0] d, input logic [2:0] l = 3'd4);
      @(negedge clk);
      wr_en = 1; wr_addr = a; wr_data = d; wr_len = l;
      #1;
      cap_init = buf_init_o; cap_cnt_we = buf_cnt_we_o; cap_cnt = buf_cnt_o; cap_wr = buf_wr_o;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic wait_ready();
      for (int i = 0; i < 64 && !status_o[7]; i++) @(negedge clk);
   endtask

   task automatic clr_seen();
      seen_prog = 0; seen_erase = 0; seen_com = 0;
   endtask

   // reference model built from the requirements
   int m_st = 0; logic [1:0] m_mode = 0; logic [7:0] m_err = 0; logic [15:0] m_lock = 0;
   bit e_prog, e_erase, e_com; logic [19:0] e_paddr; logic [31:0] e_pdata; logic [3:0] e_blk;

   task automatic m_apply(input logic [19:0] a, input logic [31:0] d);
      logic [7:0] c = d[7:0];
      e_prog = 0; e_erase = 0; e_com = 0;
      case (m_st)
         0: case (c)
               8'h90: m_mode = 2;
               8'h70: m_mode = 1;
               8'h98: m_mode = 3;
               8'h50: m_err = 0;
               8'h40, 8'h10: begin m_st = 2; m_mode = 1; end
               8'h20: begin m_st = 5; m_mode = 1; end
               8'hE8: begin m_st = 3; m_mode = 1; end
               8'h60: m_st = 1;
               8'hD0: ;
               default: m_mode = 0;
            endcase
         1: begin
               if (c == 8'h01) begin m_lock[a[19:16]] = 1; m_mode = 1; end
               else if (c == 8'hD0) begin m_lock[a[19:16]] = 0; m_mode = 1; end
               else m_err |= 8'h30;
               m_st = 0;
            end
         2: begin
               if (m_lock[a[19:16]]) m_err |= 8'h12;
               else begin e_prog = 1; e_paddr = a; e_pdata = d; end
               m_mode = 1; m_st = 0;
            end
         3: begin m_st = 4; m_mode = 1; end
         4: if (c == 8'hD0) begin
               if (m_lock[tb_base[19:16]]) m_err |= 8'h12; else e_com = 1;
               m_mode = 1; m_st = 0;
            end
         default: begin
               if (c != 8'hD0) m_err |= 8'h30;
               else if (m_lock[a[19:16]]) m_err |= 8'h12;
               else begin e_erase = 1; e_blk = a[19:16]; end
               m_mode = 1; m_st = 0;
            end
      endcase
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++; tests++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] pool [13] = '{8'h90, 8'h70, 8'h98, 8'h50, 8'h40, 8'h10, 8'h20,
                                8'hE8, 8'h60, 8'hD0, 8'hFF, 8'h01, 8'h00};
      void'($urandom(32'h5EED_F1A5));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(rd_mode_o == 0, "R1 mode", rd_mode_o, 0);
      chk(status_o == 8'h80, "R1 status", status_o, 8'h80);
      chk(lock_map_o == 0 && !prog_req_o && !erase_req_o && !buf_commit_o, "R1 locks/req", lock_map_o, 0);

      // R2/R3 mode selection, upper bits and address ignored
      do_wr(20'hA_BCDE, 32'h1234_5690);
      chk(rd_mode_o == 2, "R2 ident with junk upper bits", rd_mode_o, 2);
      do_wr(20'h0_0003, 32'hFFFF_FF70); chk(rd_mode_o == 1, "R3 status mode", rd_mode_o, 1);
      do_wr(20'hF_0000, 32'h0000_0098); chk(rd_mode_o == 3, "R3 query mode", rd_mode_o, 3);
      do_wr(20'h0_0000, 32'h0000_00D0); chk(rd_mode_o == 3, "R3 confirm ignored", rd_mode_o, 3);
      do_wr(20'h0_0000, 32'h0000_005A); chk(rd_mode_o == 0, "R3 unknown to array", rd_mode_o, 0);
      do_wr(20'h0_0000, 32'h0000_0098);
      do_wr(20'h0_0000, 32'h0000_00FF); chk(rd_mode_o == 0, "R3 array code", rd_mode_o, 0);

      // R5 lock block 3; lock-arm keeps the mode
      do_wr(20'h0_0000, 32'h98);
      do_wr(20'h0_0000, 32'h60); chk(rd_mode_o == 3, "R5 arm keeps mode", rd_mode_o, 3);
      do_wr(20'h3_0010, 32'h01);
      chk(lock_map_o == 16'h0008, "R5 lock bit", lock_map_o, 16'h0008);
      chk(rd_mode_o == 1, "R5 status mode", rd_mode_o, 1);

      // R7 erase of locked block, then R4 clear
      clr_seen();
      do_wr(20'h0, 32'h20); do_wr(20'h3_FFFC, 32'hD0); wait_ready();
      chk(status_o == 8'h92 && !seen_erase, "R7 locked erase", status_o, 8'h92);
      do_wr(20'h0, 32'h50); chk(status_o == 8'h80, "R4 clear", status_o, 8'h80);

      // R7/R9 erase of unlocked block 5
      clr_seen();
      do_wr(20'h0, 32'h20); do_wr(20'h5_1234, 32'hD0);
      chk(status_o[7] == 0 && erase_req_o, "R9 busy during erase", status_o, 8'h00);
      wait_ready();
      chk(seen_erase && s_blk == 5, "R7 erase block", s_blk, 5);
      chk(status_o == 8'h80, "R9 ready after erase", status_o, 8'h80);

      // R7 bad confirm, R10 sticky
      do_wr(20'h0, 32'h20); do_wr(20'h0, 32'h33);
      chk(status_o == 8'hB0 && rd_mode_o == 1, "R7 seq error", status_o, 8'hB0);
      do_wr(20'h0, 32'h70); do_wr(20'h0, 32'h98);
      chk(status_o == 8'hB0, "R10 sticky", status_o, 8'hB0);
      do_wr(20'h0, 32'h50);

      // R5 bad second code
      do_wr(20'h0, 32'h60); do_wr(20'h0, 32'h77);
      chk(status_o == 8'hB0, "R5 bad lock code", status_o, 8'hB0);
      do_wr(20'h0, 32'h50);

      // R6 program on locked block
      clr_seen();
      do_wr(20'h0, 32'h40); do_wr(20'h3_0100, 32'hDEAD_BEEF); wait_ready();
      chk(status_o == 8'h92 && !seen_prog, "R6 locked program", status_o, 8'h92);
      do_wr(20'h0, 32'h50);
      do_wr(20'h0, 32'h60); do_wr(20'h3_0000, 32'hD0);
      chk(lock_map_o == 0, "R5 unlock", lock_map_o, 0);

      // R6/R9 program with writes while busy
      clr_seen(); hold = 6;
      do_wr(20'h0, 32'h10); do_wr(20'h2_0A04, 32'hCAFE_BABE, 3'd2);
      chk(status_o[7] == 0, "R9 busy low", status_o, 8'h00);
      do_wr(20'h0, 32'h90);
      wait_ready(); hold = 2;
      chk(seen_prog && s_paddr == 20'h2_0A04 && s_pdata == 32'hCAFE_BABE && s_plen == 2,
          "R6 program fields", s_pdata, 32'hCAFE_BABE);
      chk(rd_mode_o == 1, "R9 write ignored while busy", rd_mode_o, 1);

      // R8 buffered program
      clr_seen();
      do_wr(20'h0, 32'h90);
      do_wr(20'h0, 32'hE8);
      chk(cap_init && rd_mode_o == 1, "R8 init pulse", cap_init, 1);
      do_wr(20'h0, 32'h07);
      chk(cap_cnt_we && cap_cnt == 8'h07, "R8 count", cap_cnt, 7);
      do_wr(tb_base, 32'h1111_2222);
      chk(cap_wr && !cap_cnt_we, "R8 data offered", cap_wr, 1);
      do_wr(tb_base + 4, 32'h3333_4444);
      do_wr(tb_base, 32'hD0); wait_ready();
      chk(seen_com && status_o == 8'h80, "R8 commit", status_o, 8'h80);

      // R8 refused non-confirm
      accept_en = 0;
      do_wr(20'h0, 32'h98);
      do_wr(20'h0, 32'hE8); do_wr(20'h0, 32'h03); do_wr(tb_base, 32'h55);
      chk(status_o == 8'h90, "R8 buffer error", status_o, 8'h90);
      do_wr(20'h0, 32'h90);
      chk(rd_mode_o == 2, "R8 back to idle", rd_mode_o, 2);
      accept_en = 1;
      do_wr(20'h0, 32'h50);

      // R8 commit with locked base block
      clr_seen();
      do_wr(20'h0, 32'h60); do_wr(tb_base, 32'h01);
      do_wr(20'h0, 32'hE8); do_wr(20'h0, 32'h01); do_wr(tb_base, 32'hAB);
      do_wr(tb_base, 32'hD0); wait_ready();
      chk(status_o == 8'h92 && !seen_com, "R8 locked commit", status_o, 8'h92);
      do_wr(20'h0, 32'h60); do_wr(tb_base, 32'hD0);
      do_wr(20'h0, 32'h50);
      do_wr(20'h0, 32'hFF);

      // random phase against the model (R2..R10)
      m_st = 0; m_mode = 0; m_err = 0; m_lock = 0;
      for (int n = 0; n < 600; n++) begin
         logic [19:0] a = 20'($urandom);
         logic [31:0] d = $urandom;
         if ($urandom_range(0, 9) != 0) d[7:0] = pool[$urandom_range(0, 12)];
         clr_seen();
         m_apply(a, d);
         do_wr(a, d);
         wait_ready();
         chk(rd_mode_o == m_mode, "R3 random mode", rd_mode_o, m_mode);
         chk(status_o == (8'h80 | m_err), "R10 random status", status_o, 8'h80 | m_err);
         chk(lock_map_o == m_lock, "R5 random locks", lock_map_o, m_lock);
         chk(seen_prog == e_prog && (!e_prog || (s_paddr == e_paddr && s_pdata == e_pdata)),
             "R6 random program", seen_prog, e_prog);
         chk(seen_erase == e_erase && (!e_erase || s_blk == e_blk), "R7 random erase", seen_erase, e_erase);
         chk(seen_com == e_com, "R8 random commit", seen_com, e_com);
      end

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule